// File: doc/BRIEF.md
# Work-RAM Bank Decoder with Write Lock

This block sits on the work-RAM side of a cartridge memory mapper. The CPU can reach work RAM in two ways. The first is the fixed 8 KB window at 0x6000–0x7FFF, whose bank comes from a 3-bit value held in register 0x5113. The second is the upper program space at 0x8000 and above, where the program-bank logic elsewhere in the mapper has picked a RAM bank and presents it on `prgRamBank` together with `prgRamHit`. Both routes feed one shared decoder. A static board-size input then turns the 3-bit bank into one of three results: a chip select, a 2-bit 8 KB bank inside that chip, or an open-bus indication.

A two-key lock gates every write to the RAM. The lock opens only while the two low bits of register 0x5102 hold 2 and the two low bits of register 0x5103 hold 1. Reads go through whatever the lock state is. The RAM arrays are outside the block. The block drives their chip selects, bank bits, offset, output enable and write enable. When an access lands on open bus, it raises `openBus` so that the surrounding logic leaves the data bus holding its previous value.

Top module: `wram_bank_lock`

## Requirements
- R1: After reset, both key registers and the window bank register read as 0. The lock is therefore closed, and a window access selects chip 0, bank 0.
- R2: A write to 0x5113 keeps data bits 2:0 as the window bank. Bits 7:3 have no effect on the decode.
- R3: With `cfgSize`=0 (8 KB board), banks 0–3 select chip 0 with `ramBank`=0, and banks 4–7 are open bus.
- R4: With `cfgSize`=1 (16 KB board, two chips), banks 0–3 select chip 0 and banks 4–7 select chip 1. In both cases `ramBank`=0.
- R5: With `cfgSize`=2 (32 KB board), banks 0–3 select chip 0 with `ramBank` equal to bank bits 1:0, and banks 4–7 are open bus.
- R6: With `cfgSize`=3, every RAM access is open bus.
- R7: An access at 0x8000 or above with `prgRamHit`=1 uses `prgRamBank` through the same decode as the window. Without `prgRamHit`, such an access drives no RAM signal. A window access ignores `prgRamBank`. `ramOff` always equals address bits 12:0.
- R8: An open-bus access raises `openBus` and asserts no chip select, no `ramOe` and no `ramWe`.
- R9: The lock is open only when the low two bits of 0x5102 equal 2 and the low two bits of 0x5103 equal 1. Bits 7:2 of either key are ignored. A key write takes effect from the next clock cycle.
- R10: While the lock is closed, a RAM write still asserts its chip select, but `ramWe` stays low.
- R11: RAM reads assert `ramOe` whether the lock is open or closed.
- R12: A key write that closes the lock, made in the same cycle as a RAM write, does not block that write. It blocks the writes that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSize | input | 2 | Board RAM size: 0=8 KB, 1=16 KB, 2=32 KB, 3=none |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 16 | Register write address |
| regWdata | input | 8 | Register write data |
| memRe | input | 1 | CPU memory read |
| memWe | input | 1 | CPU memory write |
| memAddr | input | 16 | CPU memory address |
| prgRamHit | input | 1 | Program-bank logic maps RAM at this upper address |
| prgRamBank | input | 3 | RAM bank picked by the program-bank logic |
| ramCs | output | 2 | Chip select per RAM chip |
| ramBank | output | 2 | 8 KB bank inside the selected chip |
| ramOff | output | 13 | Byte offset inside the 8 KB bank |
| ramOe | output | 1 | RAM output enable |
| ramWe | output | 1 | RAM write enable, gated by the lock |
| openBus | output | 1 | Access hit an unpopulated bank |

## Verification
A key-register write and a RAM write can happen in the same cycle, because registers and memory use separate ports. The bench opens the lock first. It then drives a RAM write at the window together with a write of 0 to 0x5103 in the same cycle. `ramWe` must be high before that clock edge and low on the repeated write after it. A second collision, a write to an open-bus bank while the lock is open, is judged by `openBus` being high and by the absence of any chip select or write enable.

// File: rtl/wram_pkg.sv
package wram_pkg;
  localparam int unsigned BANK_W = 3;

  typedef enum logic [1:0] {
    SZ_8K   = 2'd0,
    SZ_16K  = 2'd1,
    SZ_32K  = 2'd2,
    SZ_NONE = 2'd3
  } wramSizeE;

  typedef struct packed {
    logic              writeOpen;
    logic [BANK_W-1:0] winBank;
  } ctrlStrobeT;
endpackage

// File: rtl/wram_lock_ctrl.sv
module wram_lock_ctrl
  import wram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_W = 2,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 16'h5102,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 16'h5103,
  parameter logic [ADDR_W-1:0] WIN_REG_ADDR = 16'h5113,
  parameter logic [KEY_W-1:0] KEY_A_VAL = 2'd2,
  parameter logic [KEY_W-1:0] KEY_B_VAL = 2'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrobeT        strobe
);
  logic [KEY_W-1:0]  keyA;
  logic [KEY_W-1:0]  keyB;
  logic [BANK_W-1:0] winBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyA    <= '0;
      keyB    <= '0;
      winBank <= '0;
    end else if (regWe) begin
      if (regAddr == KEY_A_ADDR)   keyA    <= regWdata[KEY_W-1:0];
      if (regAddr == KEY_B_ADDR)   keyB    <= regWdata[KEY_W-1:0];
      if (regAddr == WIN_REG_ADDR) winBank <= regWdata[BANK_W-1:0];
    end
  end

  always_comb begin
    strobe.writeOpen = (keyA == KEY_A_VAL) && (keyB == KEY_B_VAL);
    strobe.winBank   = winBank;
  end
endmodule

// File: rtl/wram_bank_dp.sv
module wram_bank_dp
  import wram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned CHIP_N = 2,
  parameter int unsigned SUB_W = 2,
  parameter logic [ADDR_W-OFF_W-1:0] WIN_TAG = 3'b011
) (
  input  logic [1:0]        cfgSize,
  input  ctrlStrobeT        strobe,
  input  logic              memRe,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              prgRamHit,
  input  logic [BANK_W-1:0] prgRamBank,
  output logic [CHIP_N-1:0] ramCs,
  output logic [SUB_W-1:0]  ramBank,
  output logic [OFF_W-1:0]  ramOff,
  output logic              ramOe,
  output logic              ramWe,
  output logic              openBus
);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W;
  localparam int unsigned CHIP_W = (CHIP_N > 1) ? $clog2(CHIP_N) : 1;

  wramSizeE          sizeCfg;
  logic              winHit;
  logic              prgHit;
  logic              active;
  logic [BANK_W-1:0] bankSel;
  logic              upperHalf;
  logic              isOpen;
  logic [CHIP_W-1:0] chipIdx;
  logic [SUB_W-1:0]  subBank;
  logic              granted;

  assign sizeCfg   = wramSizeE'(cfgSize);
  assign winHit    = (memAddr[ADDR_W-1 -: TAG_W] == WIN_TAG);
  assign prgHit    = memAddr[ADDR_W-1] && prgRamHit;
  assign active    = (winHit || prgHit) && (memRe || memWe);
  assign bankSel   = winHit ? strobe.winBank : prgRamBank;
  assign upperHalf = bankSel[BANK_W-1];

  always_comb begin
    isOpen  = 1'b1;
    chipIdx = '0;
    subBank = '0;
    unique case (sizeCfg)
      SZ_8K: begin
        isOpen = upperHalf;
      end
      SZ_16K: begin
        isOpen  = 1'b0;
        chipIdx = CHIP_W'(upperHalf);
      end
      SZ_32K: begin
        isOpen  = upperHalf;
        subBank = bankSel[SUB_W-1:0];
      end
      default: begin
        isOpen = 1'b1;
      end
    endcase
  end

  assign granted = active && !isOpen;

  for (genvar g = 0; g < CHIP_N; g++) begin : g_cs
    assign ramCs[g] = granted && (chipIdx == CHIP_W'(g));
  end

  assign ramBank = granted ? subBank : '0;
  assign ramOff  = memAddr[OFF_W-1:0];
  assign ramOe   = granted && memRe;
  assign ramWe   = granted && memWe && strobe.writeOpen;
  assign openBus = active && isOpen;
endmodule

// File: rtl/wram_bank_lock.sv
module wram_bank_lock
  import wram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned CHIP_N = 2,
  parameter int unsigned SUB_W = 2,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 16'h5102,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 16'h5103,
  parameter logic [ADDR_W-1:0] WIN_REG_ADDR = 16'h5113,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgSize,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              memRe,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              prgRamHit,
  input  logic [BANK_W-1:0] prgRamBank,
  output logic [CHIP_N-1:0] ramCs,
  output logic [SUB_W-1:0]  ramBank,
  output logic [OFF_W-1:0]  ramOff,
  output logic              ramOe,
  output logic              ramWe,
  output logic              openBus
);
  localparam logic [ADDR_W-OFF_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFF_W];

  ctrlStrobeT strobe;

  wram_lock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_A_ADDR(KEY_A_ADDR), .KEY_B_ADDR(KEY_B_ADDR),
    .WIN_REG_ADDR(WIN_REG_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe)
  );

  wram_bank_dp #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CHIP_N(CHIP_N),
    .SUB_W(SUB_W), .WIN_TAG(WIN_TAG)
  ) u_dp (
    .cfgSize(cfgSize), .strobe(strobe), .memRe(memRe), .memWe(memWe),
    .memAddr(memAddr), .prgRamHit(prgRamHit), .prgRamBank(prgRamBank),
    .ramCs(ramCs), .ramBank(ramBank), .ramOff(ramOff), .ramOe(ramOe),
    .ramWe(ramWe), .openBus(openBus)
  );
endmodule

// File: rtl/wram_lock_chk.sv
module wram_lock_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CHIP_N = 2,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 16'h5102
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              memRe,
  input logic              memWe,
  input logic [CHIP_N-1:0] ramCs,
  input logic              ramOe,
  input logic              ramWe,
  input logic              openBus
);
  // R8: open bus keeps every RAM strobe quiet
  a_r8_open_quiet: assert property (@(posedge clk) disable iff (!rstN)
    openBus |-> (ramCs == '0) && !ramWe && !ramOe);

  // R4: at most one chip is selected at a time
  a_r4_one_chip: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ramCs));

  // R10: a write enable needs a CPU write and exactly one chip
  a_r10_we_has_cs: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> memWe && ($countones(ramCs) == 1));

  // R11: a selected read always gets its output enable
  a_r11_read_free: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && (ramCs != '0)) |-> ramOe);

  // R9: a wrong first key closes the lock for the next cycle
  a_r9_bad_key_locks: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == KEY_A_ADDR) && (regWdata[1:0] != 2'd2)) |=> !ramWe);
endmodule

bind wram_bank_lock wram_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_N(CHIP_N), .KEY_A_ADDR(KEY_A_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .memRe(memRe), .memWe(memWe), .ramCs(ramCs),
  .ramOe(ramOe), .ramWe(ramWe), .openBus(openBus)
);

// File: tb/sim_wram_bank_lock.sv
`timescale 1ns/1ps
module sim_wram_bank_lock;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgSize = 2'd0;
  logic        regWe = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        memRe = 1'b0;
  logic        memWe = 1'b0;
  logic [15:0] memAddr = '0;
  logic        prgRamHit = 1'b0;
  logic [2:0]  prgRamBank = '0;
  logic [1:0]  ramCs;
  logic [1:0]  ramBank;
  logic [12:0] ramOff;
  logic        ramOe;
  logic        ramWe;
  logic        openBus;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wram_bank_lock u0 (
    .clk(clk), .rstN(rstN), .cfgSize(cfgSize), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .memRe(memRe), .memWe(memWe),
    .memAddr(memAddr), .prgRamHit(prgRamHit), .prgRamBank(prgRamBank),
    .ramCs(ramCs), .ramBank(ramBank), .ramOff(ramOff), .ramOe(ramOe),
    .ramWe(ramWe), .openBus(openBus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input bit rd, input bit wr);
    @(negedge clk);
    memAddr = a; memRe = rd; memWe = wr;
    #1;
  endtask

  task automatic idle();
    memRe = 1'b0; memWe = 1'b0;
  endtask

  // Expected decode taken from R3..R6
  task automatic expDecode(input logic [1:0] cfg, input logic [2:0] bank,
                           output logic [1:0] cs, output logic [1:0] sub,
                           output bit open);
    cs = 2'b00; sub = 2'b00; open = 1'b0;
    case (cfg)
      2'd0: if (bank >= 4) open = 1; else cs = 2'b01;
      2'd1: cs = (bank >= 4) ? 2'b10 : 2'b01;
      2'd2: if (bank >= 4) open = 1; else begin cs = 2'b01; sub = bank[1:0]; end
      default: open = 1;
    endcase
  endtask

  task automatic t_reset();
    cfgSize = 2'd0;
    access(16'h6000, 1, 0);
    check(ramCs == 2'b01 && ramBank == 0, "R1 bank", {ramCs, ramBank}, 4'b0100);
    access(16'h6000, 0, 1);
    check(ramWe == 0, "R1 lock closed", ramWe, 0);
    check(ramCs == 2'b01, "R10 cs while locked", ramCs, 1);
    idle();
  endtask

  task automatic t_decode();
    logic [1:0] eCs, eSub;
    bit eOpen;
    for (int c = 0; c < 4; c++) begin
      cfgSize = c[1:0];
      for (int b = 0; b < 8; b++) begin
        regWrite(16'h5113, 8'hF8 | 8'(b));
        access(16'h7ABC, 1, 0);
        expDecode(c[1:0], b[2:0], eCs, eSub, eOpen);
        check(ramCs == eCs, (c == 0) ? "R3 cs" : (c == 1) ? "R4 cs" :
              (c == 2) ? "R5 cs" : "R6 cs", ramCs, eCs);
        check(ramBank == eSub, "R2 R5 bank", ramBank, eSub);
        check(openBus == eOpen, "R8 openBus", openBus, eOpen);
        check(ramOe == !eOpen, "R8 R11 oe", ramOe, !eOpen);
        check(ramOff == 13'h1ABC, "R7 offset", ramOff, 13'h1ABC);
        idle();
      end
    end
  endtask

  task automatic t_prg();
    logic [1:0] eCs, eSub;
    bit eOpen;
    cfgSize = 2'd2;
    regWrite(16'h5113, 8'h00);
    for (int b = 0; b < 8; b++) begin
      prgRamHit = 1; prgRamBank = b[2:0];
      access(16'h9123, 1, 0);
      expDecode(2'd2, b[2:0], eCs, eSub, eOpen);
      check(ramCs == eCs && ramBank == eSub && openBus == eOpen,
            "R7 prg decode", {ramCs, ramBank, openBus}, {eCs, eSub, eOpen});
    end
    prgRamBank = 3'd3;
    access(16'h6010, 1, 0);
    check(ramBank == 0, "R7 window ignores prg bank", ramBank, 0);
    prgRamHit = 0;
    access(16'h9123, 1, 1);
    check(ramCs == 0 && !openBus && !ramOe && !ramWe, "R7 no hit",
          {ramCs, openBus, ramOe, ramWe}, 0);
    idle();
  endtask

  task automatic t_lock();
    cfgSize = 2'd1;
    regWrite(16'h5113, 8'h05);
    regWrite(16'h5102, 8'h02);
    access(16'h6000, 0, 1);
    check(ramWe == 0, "R9 one key only", ramWe, 0);
    regWrite(16'h5103, 8'h01);
    access(16'h6000, 0, 1);
    check(ramWe == 1 && ramCs == 2'b10, "R9 open", {ramWe, ramCs}, 3'b110);
    regWrite(16'h5102, 8'hFE);
    access(16'h6000, 0, 1);
    check(ramWe == 1, "R9 upper key bits ignored", ramWe, 1);
    regWrite(16'h5103, 8'h02);
    access(16'h6000, 0, 1);
    check(ramWe == 0, "R10 dropped", ramWe, 0);
    access(16'h6000, 1, 0);
    check(ramOe == 1, "R11 read while locked", ramOe, 1);
    regWrite(16'h5102, 8'h01);
    access(16'h6000, 0, 1);
    check(ramWe == 0, "R9 swapped keys", ramWe, 0);
    idle();
  endtask

  task automatic t_collide();
    cfgSize = 2'd0;
    regWrite(16'h5113, 8'h00);
    regWrite(16'h5102, 8'h02);
    regWrite(16'h5103, 8'h01);
    @(negedge clk);
    regWe = 1; regAddr = 16'h5103; regWdata = 8'h00;
    memAddr = 16'h6123; memWe = 1; memRe = 0;
    #1;
    check(ramWe == 1, "R12 same-cycle write passes", ramWe, 1);
    @(negedge clk);
    regWe = 0;
    #1;
    check(ramWe == 0, "R12 later write blocked", ramWe, 0);
    regWrite(16'h5103, 8'h01);
    regWrite(16'h5113, 8'h06);
    access(16'h6000, 0, 1);
    check(openBus && ramCs == 0 && !ramWe, "R8 open with lock open",
          {openBus, ramCs, ramWe}, 3'b100);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_decode();
    t_prg();
    t_lock();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule